// File: doc/BRIEF.md
# Console Serial Port with Register Access

This block is a small asynchronous serial port meant to serve as a processor's text console. Software reaches it through five 64-bit registers on a simple memory-mapped bus: it writes characters into a transmit queue, reads received characters from a receive queue, and polls a status word that says whether either queue is empty or full. Both directions are buffered by a parameterised FIFO. Characters always travel as one start bit, eight data bits sent least significant bit first, and one stop bit. There is no parity and there are no modem-control lines.

A single programmable divider sets the line rate. It produces a tick every divider+1 clocks, and each bit on the line lasts sixteen ticks. Software loads the divider with clock / (16 x baud) - 1. The receiver samples each bit in the middle of its sixteen ticks and drops false start bits caused by short glitches. Two interrupt lines are available. One is raised while received data is waiting. The other is raised while the transmit queue has drained. Each line has its own enable bit.

Top module: `con_uart`

## Requirements
- R1: After reset, the status register reads 0x3, the divider and interrupt-enable registers read 0, both interrupt outputs are low and `serial_tx` is high.
- R2: Register byte offsets: 0x00 transmit data (write, bits 7:0), 0x08 receive data (read), 0x10 status (read), 0x18 divider (read/write, DIV_W bits), 0x20 interrupt enable (read/write, bits 1:0). A read of any other offset returns 0. Read data appears on `bus_rdata` in the cycle after `bus_rd`.
- R3: The oversampling tick fires once every divider+1 clocks. Each transmitted data bit lasts exactly 16 x (divider+1) clocks.
- R4: The transmitter sends queued bytes in write order as 8N1 frames: start bit low, data bits LSB first, stop bit high. The line idles high.
- R5: A write to transmit data while the transmit FIFO is full is dropped. Status bit 3 reports transmit FIFO full.
- R6: The receiver samples each bit at the midpoint of its 16 ticks. It stores the byte only if the stop bit samples high; a frame with a low stop bit is discarded.
- R7: A start bit that is no longer low at its midpoint (8 ticks after the falling edge) is discarded and no byte is stored.
- R8: A frame that completes while the receive FIFO is full is dropped. Status bit 2 reports receive FIFO full.
- R9: A read of receive data while the receive FIFO is empty returns 0 and leaves the FIFO unchanged. Otherwise the read returns the oldest byte in bits 7:0 and removes it.
- R10: Status bit 0 is 1 when the receive FIFO is empty. Status bit 1 is 1 when the transmit FIFO is empty.
- R11: `irq_rx` equals enable bit 0 AND receive FIFO not empty. `irq_tx` equals enable bit 1 AND transmit FIFO empty. Both are registered, so they follow their conditions one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 6 | Register byte offset |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rd | input | 1 | Read strobe, one cycle |
| bus_wdata | input | 64 | Write data |
| bus_rdata | output | 64 | Registered read data |
| serial_rx | input | 1 | Serial receive line |
| serial_tx | output | 1 | Serial transmit line |
| irq_rx | output | 1 | Receive-data-waiting interrupt |
| irq_tx | output | 1 | Transmit-queue-drained interrupt |

## Verification
The assertions assume the bus master never raises read and write in the same cycle. They also assume the divider is rewritten only while both serial directions are idle, so tick spacing stays regular within a frame. The bench issues one strobe at a time, separated by a quiet cycle. It changes the divider only after the transmit monitor has collected every expected frame and no receive frame is being driven. Its serial driver holds each bit for exactly 16 x (divider+1) clocks, with bytes drawn from a seeded random source.

// File: rtl/con_uart_pkg.sv
package con_uart_pkg;
  localparam int REG_AW = 6;
  localparam logic [REG_AW-1:0] OFF_TXD  = 6'h00;
  localparam logic [REG_AW-1:0] OFF_RXD  = 6'h08;
  localparam logic [REG_AW-1:0] OFF_STAT = 6'h10;
  localparam logic [REG_AW-1:0] OFF_DIV  = 6'h18;
  localparam logic [REG_AW-1:0] OFF_IEN  = 6'h20;
  localparam int OVS       = 16;
  localparam int DATA_BITS = 8;
  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_state_t;
endpackage

// File: rtl/con_uart_fifo.sv
module con_uart_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         empty,
  output logic         full
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0] mem [DEPTH];
  logic [AW:0]  wptr, rptr;

  always_ff @(posedge clk) begin
    if (push) mem[wptr[AW-1:0]] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr <= '0;
      rptr <= '0;
    end else begin
      if (push) wptr <= wptr + 1'b1;
      if (pop)  rptr <= rptr + 1'b1;
    end
  end

  assign rdata = mem[rptr[AW-1:0]];
  assign empty = (wptr == rptr);
  assign full  = (wptr[AW-1:0] == rptr[AW-1:0]) && (wptr[AW] != rptr[AW]);

  // R5 / R8: the owner never pushes into a full queue
  p_no_overflow_r5: assert property (@(posedge clk) disable iff (rst) !(push && full));
  // R9: the owner never pops an empty queue
  p_no_underflow_r9: assert property (@(posedge clk) disable iff (rst) !(pop && empty));
endmodule

// File: rtl/con_uart_tick.sv
module con_uart_tick #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt >= div) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end

  // R3: with a nonzero divider two ticks are never adjacent
  p_tick_gap_r3: assert property (@(posedge clk) disable iff (rst)
    (tick && div != '0 && $stable(div)) |=> !tick);
endmodule

// File: rtl/con_uart_tx.sv
module con_uart_tx
  import con_uart_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 tick,
  input  logic                 fifo_empty,
  input  logic [DATA_BITS-1:0] fifo_data,
  output logic                 fifo_pop,
  output logic                 txd
);
  localparam int NBITS = DATA_BITS + 2;
  localparam int TCW   = $clog2(OVS);
  localparam int BCW   = $clog2(NBITS);
  localparam logic [TCW-1:0] TC_LAST = TCW'(OVS - 1);
  localparam logic [BCW-1:0] BC_LAST = BCW'(NBITS - 1);

  logic             busy;
  logic [NBITS-1:0] sh;
  logic [TCW-1:0]   tcnt;
  logic [BCW-1:0]   bcnt;

  assign fifo_pop = !busy && !fifo_empty;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      txd  <= 1'b1;
      sh   <= '1;
      tcnt <= '0;
      bcnt <= '0;
    end else if (fifo_pop) begin
      busy <= 1'b1;
      sh   <= {1'b1, fifo_data, 1'b0};
      txd  <= 1'b0;
      tcnt <= '0;
      bcnt <= '0;
    end else if (busy && tick) begin
      if (tcnt == TC_LAST) begin
        tcnt <= '0;
        if (bcnt == BC_LAST) begin
          busy <= 1'b0;
          txd  <= 1'b1;
        end else begin
          bcnt <= bcnt + 1'b1;
          sh   <= {1'b1, sh[NBITS-1:1]};
          txd  <= sh[1];
        end
      end else begin
        tcnt <= tcnt + 1'b1;
      end
    end
  end

  // R4: the line is high whenever no frame is in flight
  p_idle_high_r4: assert property (@(posedge clk) disable iff (rst) !busy |-> txd);
  // R4: a frame always begins with a low start bit
  p_start_low_r4: assert property (@(posedge clk) disable iff (rst) fifo_pop |=> !txd);
endmodule

// File: rtl/con_uart_rx.sv
module con_uart_rx
  import con_uart_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 tick,
  input  logic                 rxd,
  output logic                 push,
  output logic [DATA_BITS-1:0] data
);
  localparam int TCW = $clog2(OVS);
  localparam int BCW = $clog2(DATA_BITS);
  localparam logic [TCW-1:0] TC_HALF = TCW'(OVS / 2 - 1);
  localparam logic [TCW-1:0] TC_LAST = TCW'(OVS - 1);
  localparam logic [BCW-1:0] BI_LAST = BCW'(DATA_BITS - 1);

  logic      s1, s2;
  rx_state_t st;
  logic [TCW-1:0] tcnt;
  logic [BCW-1:0] bidx;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= 1'b1;
      s2 <= 1'b1;
    end else begin
      s1 <= rxd;
      s2 <= s1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= RX_IDLE;
      tcnt <= '0;
      bidx <= '0;
      data <= '0;
      push <= 1'b0;
    end else begin
      push <= 1'b0;
      unique case (st)
        RX_IDLE: if (!s2) begin
          st   <= RX_START;
          tcnt <= '0;
        end
        RX_START: if (tick) begin
          if (tcnt == TC_HALF) begin
            tcnt <= '0;
            bidx <= '0;
            st   <= s2 ? RX_IDLE : RX_DATA;
          end else tcnt <= tcnt + 1'b1;
        end
        RX_DATA: if (tick) begin
          if (tcnt == TC_LAST) begin
            tcnt <= '0;
            data <= {s2, data[DATA_BITS-1:1]};
            if (bidx == BI_LAST) st <= RX_STOP;
            else bidx <= bidx + 1'b1;
          end else tcnt <= tcnt + 1'b1;
        end
        RX_STOP: if (tick) begin
          if (tcnt == TC_LAST) begin
            st   <= RX_IDLE;
            push <= s2;
          end else tcnt <= tcnt + 1'b1;
        end
        default: st <= RX_IDLE;
      endcase
    end
  end

  // R6: a byte is only delivered when the stop sample was high
  p_stop_high_r6: assert property (@(posedge clk) disable iff (rst) push |-> $past(s2));
  // R6: delivery is a single-cycle pulse
  p_push_pulse_r6: assert property (@(posedge clk) disable iff (rst) push |=> !push);
endmodule

// File: rtl/con_uart.sv
module con_uart
  import con_uart_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int DIV_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [REG_AW-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [63:0]       bus_wdata,
  output logic [63:0]       bus_rdata,
  input  logic              serial_rx,
  output logic              serial_tx,
  output logic              irq_rx,
  output logic              irq_tx
);
  logic [DIV_W-1:0] div_q;
  logic [1:0]       ien_q;
  logic             tick;

  logic                 txf_push, txf_pop, txf_empty, txf_full;
  logic [DATA_BITS-1:0] txf_rdata;
  logic                 rxf_push, rxf_pop, rxf_empty, rxf_full;
  logic [DATA_BITS-1:0] rxf_rdata, rx_byte;
  logic                 rx_done;

  assign txf_push = bus_wr && (bus_addr == OFF_TXD) && !txf_full;
  assign rxf_push = rx_done && !rxf_full;
  assign rxf_pop  = bus_rd && (bus_addr == OFF_RXD) && !rxf_empty;

  con_uart_tick #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst(rst), .div(div_q), .tick(tick));

  con_uart_fifo #(.W(DATA_BITS), .DEPTH(DEPTH)) u_txf (
    .clk(clk), .rst(rst), .push(txf_push), .wdata(bus_wdata[DATA_BITS-1:0]),
    .pop(txf_pop), .rdata(txf_rdata), .empty(txf_empty), .full(txf_full));

  con_uart_tx u_tx (
    .clk(clk), .rst(rst), .tick(tick), .fifo_empty(txf_empty),
    .fifo_data(txf_rdata), .fifo_pop(txf_pop), .txd(serial_tx));

  con_uart_rx u_rx (
    .clk(clk), .rst(rst), .tick(tick), .rxd(serial_rx),
    .push(rx_done), .data(rx_byte));

  con_uart_fifo #(.W(DATA_BITS), .DEPTH(DEPTH)) u_rxf (
    .clk(clk), .rst(rst), .push(rxf_push), .wdata(rx_byte),
    .pop(rxf_pop), .rdata(rxf_rdata), .empty(rxf_empty), .full(rxf_full));

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q <= '0;
      ien_q <= '0;
    end else if (bus_wr) begin
      if (bus_addr == OFF_DIV) div_q <= bus_wdata[DIV_W-1:0];
      if (bus_addr == OFF_IEN) ien_q <= bus_wdata[1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else begin
      bus_rdata <= '0;
      if (bus_rd) begin
        unique case (bus_addr)
          OFF_RXD:  bus_rdata <= rxf_empty ? 64'd0 : 64'(rxf_rdata);
          OFF_STAT: bus_rdata <= 64'({txf_full, rxf_full, txf_empty, rxf_empty});
          OFF_DIV:  bus_rdata <= 64'(div_q);
          OFF_IEN:  bus_rdata <= 64'(ien_q);
          default:  bus_rdata <= '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_rx <= 1'b0;
      irq_tx <= 1'b0;
    end else begin
      irq_rx <= ien_q[0] && !rxf_empty;
      irq_tx <= ien_q[1] && txf_empty;
    end
  end

  // R11: an interrupt is only raised if its enable was set the cycle before
  p_irq_rx_en_r11: assert property (@(posedge clk) disable iff (rst) irq_rx |-> $past(ien_q[0]));
  p_irq_tx_en_r11: assert property (@(posedge clk) disable iff (rst) irq_tx |-> $past(ien_q[1]));
  // R9: an empty-queue data read returns zero
  p_empty_read_r9: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == OFF_RXD && rxf_empty) |=> bus_rdata == 64'd0);
endmodule

// File: tb/con_uart_bench.sv
module con_uart_bench;
  import con_uart_pkg::*;

  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [5:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [63:0] bus_wdata = '0;
  logic [63:0] bus_rdata;
  logic        rx_line = 1'b1;
  logic        serial_tx, irq_rx, irq_tx;

  int n_cmp = 0;
  int n_bad = 0;
  int bt = 32;
  logic [7:0] mon_q[$];

  always #2 clk = ~clk;

  con_uart #(.DEPTH(DEPTH), .DIV_W(16)) u_con_uart (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .serial_rx(rx_line),
    .serial_tx(serial_tx), .irq_rx(irq_rx), .irq_tx(irq_tx));

  function automatic logic [63:0] exp_status(int rxn, int txn);
    return 64'({txn >= DEPTH, rxn >= DEPTH, txn == 0, rxn == 0});
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [5:0] a, input logic [63:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [5:0] a, output logic [63:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic send_frame(input logic [7:0] b);
    @(negedge clk);
    rx_line = 1'b0;
    repeat (bt) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rx_line = b[i];
      repeat (bt) @(negedge clk);
    end
    rx_line = 1'b1;
    repeat (bt + 4) @(negedge clk);
  endtask

  task automatic wait_mon(input int n);
    for (int k = 0; k < n * 12 * bt && mon_q.size() < n; k++) @(negedge clk);
  endtask

  // transmit line monitor: mid-bit sampling
  always begin
    logic [7:0] b;
    @(negedge serial_tx);
    repeat (bt / 2) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      repeat (bt) @(negedge clk);
      b[i] = serial_tx;
    end
    repeat (bt) @(negedge clk);
    check("R4 stop bit high", 64'(serial_tx), 64'd1);
    mon_q.push_back(b);
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [63:0] d;
    logic [7:0]  exp_q[$];
    int          cnt;
    int          seed;
    seed = $urandom(32'h5eed);

    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    check("R1 serial_tx idle", 64'(serial_tx), 64'd1);
    check("R1 irq_rx", 64'(irq_rx), 64'd0);
    check("R1 irq_tx", 64'(irq_tx), 64'd0);
    bus_read(OFF_STAT, d); check("R1 status", d, exp_status(0, 0));
    bus_read(OFF_DIV, d);  check("R1 divider", d, 64'd0);
    bus_read(OFF_IEN, d);  check("R1 irq enable", d, 64'd0);

    // R2 register access
    bus_write(OFF_DIV, 64'd1);
    bus_read(OFF_DIV, d);  check("R2 divider readback", d, 64'd1);
    bus_write(OFF_IEN, 64'hFF);
    bus_read(OFF_IEN, d);  check("R2 enable width", d, 64'd3);
    bus_write(OFF_IEN, 64'd0);
    bus_read(6'h28, d);    check("R2 unmapped read", d, 64'd0);
    bus_write(OFF_STAT, 64'hF);
    bus_read(OFF_STAT, d); check("R2 status write ignored", d, exp_status(0, 0));

    // R9 read of empty receive queue
    bus_read(OFF_RXD, d);  check("R9 empty read", d, 64'd0);
    bus_read(OFF_STAT, d); check("R9 status after empty read", d, exp_status(0, 0));

    // R4 random transmit bytes
    exp_q.delete();
    for (int i = 0; i < 8; i++) begin
      logic [7:0] b;
      b = 8'($urandom);
      exp_q.push_back(b);
      bus_write(OFF_TXD, 64'(b));
    end
    wait_mon(8);
    check("R4 frame count", 64'(mon_q.size()), 64'd8);
    for (int i = 0; i < 8 && mon_q.size() > 0; i++)
      check("R4 tx byte", 64'(mon_q.pop_front()), 64'(exp_q[i]));
    mon_q.delete();

    // R5 overflow of the transmit queue
    exp_q.delete();
    for (int i = 0; i < DEPTH + 3; i++) begin
      logic [7:0] b;
      b = 8'(8'h40 + i);
      if (i < DEPTH + 1) exp_q.push_back(b);
      bus_write(OFF_TXD, 64'(b));
    end
    bus_read(OFF_STAT, d); check("R5 status full", d, exp_status(0, DEPTH));
    wait_mon(DEPTH + 1);
    repeat (4 * bt) @(negedge clk);
    check("R5 frames sent", 64'(mon_q.size()), 64'(DEPTH + 1));
    for (int i = 0; i <= DEPTH && mon_q.size() > 0; i++)
      check("R5 tx order", 64'(mon_q.pop_front()), 64'(exp_q[i]));
    mon_q.delete();
    bus_read(OFF_STAT, d); check("R10 tx drained", d, exp_status(0, 0));

    // R11 transmit interrupt
    bus_write(OFF_IEN, 64'd2);
    repeat (2) @(negedge clk);
    check("R11 irq_tx empty", 64'(irq_tx), 64'd1);
    bus_write(OFF_TXD, 64'h11);
    bus_write(OFF_TXD, 64'h22);
    repeat (2) @(negedge clk);
    check("R11 irq_tx queued", 64'(irq_tx), 64'd0);
    bus_read(OFF_STAT, d); check("R10 tx not empty", d, 64'd1);
    wait_mon(2);
    check("R11 irq_tx drained", 64'(irq_tx), 64'd1);
    check("R4 byte a", 64'(mon_q.pop_front()), 64'h11);
    check("R4 byte b", 64'(mon_q.pop_front()), 64'h22);
    mon_q.delete();
    repeat (2 * bt) @(negedge clk);
    bus_write(OFF_IEN, 64'd0);

    // R3 divider sets bit time
    bt = 48;
    bus_write(OFF_DIV, 64'd2);
    bus_write(OFF_TXD, 64'h0F);
    while (serial_tx !== 1'b0) @(negedge clk);
    while (serial_tx !== 1'b1) @(negedge clk);
    cnt = 0;
    while (serial_tx === 1'b1 && cnt < 1000) begin
      @(negedge clk);
      cnt++;
    end
    check("R3 four bit times", 64'(cnt), 64'(4 * 48));
    wait_mon(1);
    check("R3 byte", 64'(mon_q.pop_front()), 64'h0F);
    mon_q.delete();
    repeat (2 * bt) @(negedge clk);
    bt = 32;
    bus_write(OFF_DIV, 64'd1);

    // R6 receive random bytes, R11 receive interrupt
    bus_write(OFF_IEN, 64'd1);
    for (int i = 0; i < 10; i++) begin
      logic [7:0] b;
      b = (i == 0) ? 8'h00 : (i == 1) ? 8'hFF : 8'($urandom);
      send_frame(b);
      check("R11 irq_rx pending", 64'(irq_rx), 64'd1);
      bus_read(OFF_STAT, d); check("R10 rx not empty", d, 64'h2);
      bus_read(OFF_RXD, d);  check("R6 rx byte", d, 64'(b));
      repeat (2) @(negedge clk);
      check("R11 irq_rx cleared", 64'(irq_rx), 64'd0);
    end
    bus_write(OFF_IEN, 64'd0);

    // R7 short start glitch
    @(negedge clk);
    rx_line = 1'b0;
    repeat (4 * 2) @(negedge clk);
    rx_line = 1'b1;
    repeat (12 * bt) @(negedge clk);
    bus_read(OFF_STAT, d); check("R7 glitch ignored", d, exp_status(0, 0));

    // R6 low stop bit discards frame
    @(negedge clk);
    rx_line = 1'b0;
    repeat (bt) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rx_line = 1'b1;
      repeat (bt) @(negedge clk);
    end
    rx_line = 1'b0;
    repeat (3 * bt / 4) @(negedge clk);
    rx_line = 1'b1;
    repeat (12 * bt) @(negedge clk);
    bus_read(OFF_STAT, d); check("R6 bad stop dropped", d, exp_status(0, 0));

    // R8 receive overflow
    exp_q.delete();
    for (int i = 0; i < DEPTH + 1; i++) begin
      logic [7:0] b;
      b = 8'($urandom);
      exp_q.push_back(b);
      send_frame(b);
    end
    bus_read(OFF_STAT, d); check("R8 status full", d, exp_status(DEPTH, 0));
    for (int i = 0; i < DEPTH; i++) begin
      bus_read(OFF_RXD, d); check("R8 rx order", d, 64'(exp_q[i]));
    end
    bus_read(OFF_RXD, d);  check("R8 extra frame dropped", d, 64'd0);
    bus_read(OFF_STAT, d); check("R10 rx drained", d, exp_status(0, 0));

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule